// File: doc/BRIEF.md
# Merging Write Buffer with Read-Miss Conflict Check

This block sits between a write-through cache and the memory port. A store is handed to it and the processor moves on without waiting for memory. The buffer keeps a few entries, each covering one aligned memory block with a valid bit for every word. A store to a block that already has a waiting entry merges into that entry instead of taking a new slot. Entries leave for memory oldest first, and each departure carries only the words that were written, qualified by a word mask.

When the cache takes a read miss, the miss block is compared against every held entry. A hit raises a conflict flag, so the miss is not sent ahead of a pending write to the same block. The entry at the front of the drain queue is always on offer to memory and is locked. A store to its block opens a fresh entry behind it, so the write order to memory is kept. The buffer works the same way behind a write-back cache.

Top module: `merge_wbuf`

## Requirements
- R1: After a synchronous reset the buffer is empty: `dr_valid` and `rd_conflict` are low and `st_ready` is high.
- R2: `st_ready` is high whenever fewer than DEPTH entries are held. A store is taken on a rising edge where `st_valid` and `st_ready` are both high.
- R3: A taken store whose block matches a held entry other than the oldest merges into that entry. It sets the word's mask bit and overwrites the stored word. No new entry is used.
- R4: The oldest entry is never a merge target. A taken store to its block with no other matching entry opens a new entry at the tail.
- R5: When all DEPTH entries are held and the store has no merge target, `st_ready` is low and the store is not taken.
- R6: `dr_valid` is high exactly when at least one entry is held. `dr_addr`, `dr_mask` and the valid words of `dr_data` describe the oldest entry. They hold unchanged until an edge where `dr_ready` is high, which removes that entry.
- R7: Bits [log2(WORDS)-1:0] of `st_addr` select the word within the block, and the upper bits are the block address. Mask bit w marks word w, which is carried in `dr_data[w*DATA_W +: DATA_W]`. A newly opened entry has only the stored word's mask bit set. Words whose mask bit is clear carry no defined data.
- R8: `rd_conflict` is high in the same cycle exactly when `rd_blk` equals the block address of any held entry, the oldest one included.
- R9: A store and a drain on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data word |
| st_ready | output | 1 | Store can be taken this cycle |
| dr_valid | output | 1 | Oldest entry offered to memory |
| dr_addr | output | ADDR_W-log2(WORDS) | Block address of the oldest entry |
| dr_data | output | WORDS*DATA_W | Block data of the oldest entry |
| dr_mask | output | WORDS | Written words of the oldest entry |
| dr_ready | input | 1 | Memory takes the offered entry |
| rd_blk | input | ADDR_W-log2(WORDS) | Block address of a read miss |
| rd_conflict | output | 1 | Read-miss block is held in the buffer |

## Verification
The assertions assume that `dr_ready`, `st_valid` and both addresses are steady around each rising edge. The bench therefore changes every input half a period before the edge. The head-hold property assumes no store can ever reach the offered entry, and the stimulus tests this by aiming stores at the head's block over and over. Addresses come from a small set of blocks so that merges, head-block stores and conflicts happen often. The drain-ready pattern moves from rarely ready, which forces the full stall, to always ready.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // distance of slot idx from base in a ring of depth slots
  function automatic int ring_rel(input int idx, input int base, input int depth);
    return (idx - base + depth) % depth;
  endfunction
endpackage

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 14
) (
  input  logic [DEPTH*BLK_W-1:0] tags_flat,
  input  logic [DEPTH-1:0]       occ,
  input  logic [BLK_W-1:0]       key,
  output logic [DEPTH-1:0]       hit
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = occ[g] && (tags_flat[g*BLK_W +: BLK_W] == key);
  end
endmodule

// File: rtl/wbuf_entry.sv
module wbuf_entry #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int BLK_W  = 14,
  localparam int WI_W  = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc,
  input  logic                    merge,
  input  logic [WI_W-1:0]         word_sel,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [BLK_W-1:0]        blk_in,
  output logic [BLK_W-1:0]        blk_q,
  output logic [WORDS-1:0]        mask_q,
  output logic [WORDS*DATA_W-1:0] data_q
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  sel_oh;

  assign sel_oh = WORDS'(1) << word_sel;

  // data words carry no reset so the array maps onto plain RAM
  always_ff @(posedge clk) begin
    if (alloc || merge) mem[word_sel] <= wdata;
    if (alloc) blk_q <= blk_in;
  end

  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '0;
    else if (alloc) mask_q <= sel_oh;
    else if (merge) mask_q <= mask_q | sel_oh;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_out
    assign data_q[w*DATA_W +: DATA_W] = mem[w];
  end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
  import wbuf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              st_valid,
  input  logic [ADDR_W-1:0]                 st_addr,
  input  logic [DATA_W-1:0]                 st_data,
  output logic                              st_ready,
  output logic                              dr_valid,
  output logic [ADDR_W-$clog2(WORDS)-1:0]   dr_addr,
  output logic [WORDS*DATA_W-1:0]           dr_data,
  output logic [WORDS-1:0]                  dr_mask,
  input  logic                              dr_ready,
  input  logic [ADDR_W-$clog2(WORDS)-1:0]   rd_blk,
  output logic                              rd_conflict
);
  localparam int WI_W  = $clog2(WORDS);
  localparam int BLK_W = ADDR_W - WI_W;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]              head_q;
  logic [CNT_W-1:0]              count_q;
  logic [DEPTH*BLK_W-1:0]        tags_flat;
  logic [DEPTH*WORDS-1:0]        mask_flat;
  logic [DEPTH*WORDS*DATA_W-1:0] data_flat;
  logic [DEPTH-1:0]              occ, not_head, merge_ok;
  logic [DEPTH-1:0]              st_match, rd_match, alloc_v, merge_v;
  logic [PTR_W-1:0]              alloc_idx;
  logic                          merge_any, full, st_take, pop;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      occ[i]      = CNT_W'(ring_rel(i, int'(head_q), DEPTH)) < count_q;
      not_head[i] = PTR_W'(i) != head_q;
    end
  end

  assign merge_ok = occ & not_head;

  wbuf_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_st_match (
    .tags_flat(tags_flat), .occ(merge_ok),
    .key(st_addr[ADDR_W-1:WI_W]), .hit(st_match)
  );

  wbuf_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_rd_match (
    .tags_flat(tags_flat), .occ(occ), .key(rd_blk), .hit(rd_match)
  );

  assign merge_any = |st_match;
  assign full      = count_q == CNT_W'(DEPTH);
  assign st_ready  = merge_any || !full;
  assign st_take   = st_valid && st_ready;
  assign alloc_idx = PTR_W'((int'(head_q) + int'(count_q)) % DEPTH);
  assign dr_valid  = count_q != '0;
  assign pop       = dr_valid && dr_ready;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      alloc_v[i] = st_take && !merge_any && (alloc_idx == PTR_W'(i));
      merge_v[i] = st_take && st_match[i];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    wbuf_entry #(.DATA_W(DATA_W), .WORDS(WORDS), .BLK_W(BLK_W)) u_ent (
      .clk(clk), .rst(rst), .alloc(alloc_v[g]), .merge(merge_v[g]),
      .word_sel(st_addr[WI_W-1:0]), .wdata(st_data),
      .blk_in(st_addr[ADDR_W-1:WI_W]),
      .blk_q(tags_flat[g*BLK_W +: BLK_W]),
      .mask_q(mask_flat[g*WORDS +: WORDS]),
      .data_q(data_flat[g*WORDS*DATA_W +: WORDS*DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop) head_q <= PTR_W'((int'(head_q) + 1) % DEPTH);
      count_q <= count_q + CNT_W'(st_take && !merge_any) - CNT_W'(pop);
    end
  end

  assign dr_addr     = tags_flat[int'(head_q)*BLK_W +: BLK_W];
  assign dr_mask     = mask_flat[int'(head_q)*WORDS +: WORDS];
  assign dr_data     = data_flat[int'(head_q)*WORDS*DATA_W +: WORDS*DATA_W];
  assign rd_conflict = |rd_match;
endmodule

// File: rtl/merge_wbuf_chk.sv
module merge_wbuf_chk #(
  parameter int DEPTH  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 14,
  parameter int CNT_W  = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    st_ready,
  input logic                    dr_valid,
  input logic                    dr_ready,
  input logic [BLK_W-1:0]        dr_addr,
  input logic [WORDS-1:0]        dr_mask,
  input logic [WORDS*DATA_W-1:0] dr_data,
  input logic                    rd_conflict,
  input logic [CNT_W-1:0]        held
);
  assert_room_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (held < CNT_W'(DEPTH)) |-> st_ready);

  assert_stall_only_full_R5: assert property (@(posedge clk) disable iff (rst)
    !st_ready |-> (held == CNT_W'(DEPTH)));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    held <= CNT_W'(DEPTH));

  assert_head_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_mask) && $stable(dr_data)));

  assert_mask_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    dr_valid |-> (dr_mask != '0));

  assert_conflict_needs_entry_R8: assert property (@(posedge clk) disable iff (rst)
    rd_conflict |-> dr_valid);
endmodule

bind merge_wbuf merge_wbuf_chk #(
  .DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .BLK_W(BLK_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .st_ready(st_ready), .dr_valid(dr_valid),
  .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_mask(dr_mask),
  .dr_data(dr_data), .rd_conflict(rd_conflict), .held(count_q)
);

// File: tb/merge_wbuf_tb_top.sv
`timescale 1ns/100ps
module merge_wbuf_tb_top;
  localparam int DEPTH  = 4;
  localparam int WORDS  = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int WI_W   = 2;
  localparam int BLK_W  = ADDR_W - WI_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_valid = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic [DATA_W-1:0] st_data = '0;
  logic st_ready;
  logic dr_valid;
  logic [BLK_W-1:0] dr_addr;
  logic [WORDS*DATA_W-1:0] dr_data;
  logic [WORDS-1:0] dr_mask;
  logic dr_ready = 1'b0;
  logic [BLK_W-1:0] rd_blk = '0;
  logic rd_conflict;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int unsigned blk;
    bit [3:0]    mask;
    logic [31:0] w [4];
  } ent_t;
  ent_t q [$];

  always #2.5 clk = ~clk;

  merge_wbuf #(.DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_ready(st_ready), .dr_valid(dr_valid), .dr_addr(dr_addr), .dr_data(dr_data),
    .dr_mask(dr_mask), .dr_ready(dr_ready), .rd_blk(rd_blk), .rd_conflict(rd_conflict)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs with the model, then advance the model over the coming edge
  task automatic step_model();
    int mj;
    bit exp_valid, exp_ready, exp_conf, take, pop;
    int unsigned sblk;
    int sw;
    ent_t e;
    exp_valid = q.size() != 0;
    chk(dr_valid == exp_valid, "R6 R9 dr_valid", dr_valid, exp_valid);
    if (exp_valid) begin
      chk(dr_addr == q[0].blk[BLK_W-1:0], "R6 R4 dr_addr", dr_addr, q[0].blk);
      chk(dr_mask == q[0].mask, "R3 R7 dr_mask", dr_mask, q[0].mask);
      for (int w = 0; w < WORDS; w++)
        if (q[0].mask[w])
          chk(dr_data[w*DATA_W +: DATA_W] == q[0].w[w], "R7 R3 dr_data",
              dr_data[w*DATA_W +: DATA_W], q[0].w[w]);
    end
    sblk = int'(st_addr[ADDR_W-1:WI_W]);
    sw = int'(st_addr[WI_W-1:0]);
    mj = -1;
    for (int j = 1; j < q.size(); j++) if (q[j].blk == sblk) mj = j;
    exp_ready = (mj >= 0) || (q.size() < DEPTH);
    chk(st_ready == exp_ready, "R2 R5 st_ready", st_ready, exp_ready);
    exp_conf = 1'b0;
    for (int j = 0; j < q.size(); j++) if (q[j].blk == int'(rd_blk)) exp_conf = 1'b1;
    chk(rd_conflict == exp_conf, "R8 rd_conflict", rd_conflict, exp_conf);
    take = st_valid && exp_ready;
    pop = exp_valid && dr_ready;
    if (take) begin
      if (mj >= 0) begin
        q[mj].mask[sw] = 1'b1;
        q[mj].w[sw] = st_data;
      end else begin
        e.blk = sblk;
        e.mask = 4'b0;
        e.mask[sw] = 1'b1;
        for (int w = 0; w < WORDS; w++) e.w[w] = '0;
        e.w[sw] = st_data;
        q.push_back(e);
      end
    end
    if (pop) void'(q.pop_front());
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: state right after reset
    chk(dr_valid == 1'b0, "R1 dr_valid", dr_valid, 0);
    chk(st_ready == 1'b1, "R1 st_ready", st_ready, 1);
    chk(rd_conflict == 1'b0, "R1 rd_conflict", rd_conflict, 0);

    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (c < 800) begin
        // rare drains: buffer fills and stalls (R5)
        st_valid = ($urandom_range(0, 3) != 0);
        dr_ready = ($urandom_range(0, 7) == 0);
        b = $urandom_range(0, 5);
      end else if (c < 1800) begin
        st_valid = $urandom_range(0, 1);
        dr_ready = $urandom_range(0, 1);
        b = $urandom_range(0, 3);
      end else if (c < 2800) begin
        // two hot blocks, slow drain: merges and head-block stores (R3, R4)
        st_valid = 1'b1;
        dr_ready = ($urandom_range(0, 3) == 0);
        b = $urandom_range(0, 1);
      end else begin
        // store and drain together each edge (R9)
        st_valid = $urandom_range(0, 1);
        dr_ready = 1'b1;
        b = $urandom_range(0, 7);
      end
      st_addr = {BLK_W'(b + 16'h0120), WI_W'($urandom_range(0, 3))};
      st_data = $urandom;
      rd_blk = BLK_W'($urandom_range(0, 7) + 16'h0120);
      #1;
      step_model();
    end

    // drain out fully
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      st_valid = 1'b0;
      dr_ready = 1'b1;
      #1;
      step_model();
    end
    @(negedge clk);
    #1;
    chk(dr_valid == 1'b0, "R6 drained empty", dr_valid, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule